// File: doc/BRIEF.md
# Nine-bit UART address filter

This block sits after a UART receiver that runs in multidrop mode. For each completed frame it decides whether to raise the receive-ready flag seen by software. In the two nine-bit serial modes, a ninth bit of 1 marks the byte as an address and a ninth bit of 0 marks it as data. While the filter is enabled, hardware compares each address byte against a masked station address and a broadcast pattern. Data bytes and non-matching addresses never reach software.

After a station sees its own address, software clears the filter enable through a one-bit synchronous write port, and the data frames that follow are accepted. In the 8-bit asynchronous mode the enable instead means "accept only frames with a good stop bit". In the shift-register mode the enable does nothing. The block also keeps the ninth bit of the last accepted frame and a per-frame address-hit indication.

Top module: `uart_addr_filter`

## Requirements
- R1: While `rst` is high, at the next clock edge `rx_ready`, `bit9_q`, `addr_match` and `filt_en` all become 0.
- R2: With `filt_en` at 0, every `frame_done` pulse sets `rx_ready` at that clock edge, in every mode.
- R3: With `filt_en` at 1 and `mode` 2 or 3, a frame whose ninth bit is 0 does not set `rx_ready`.
- R4: In mode 2 or 3 with `filt_en` at 1, an address frame (ninth bit 1) is accepted when `((rx_byte ^ slave_addr) & addr_mask) == 0`. Mask bits at 0 are don't-care. For example, address C0h with mask FDh accepts C0h and C2h, and with mask FEh accepts C1h but rejects C2h.
- R5: An address frame is also accepted when every bit that is 1 in `slave_addr | addr_mask` is also 1 in `rx_byte`. Zero bits of that broadcast pattern are don't-care.
- R6: In mode 1 with `filt_en` at 1, a frame sets `rx_ready` only when `stop_ok` is 1.
- R7: In mode 0 the value of `filt_en` has no effect, and every frame sets `rx_ready`.
- R8: `rx_ready` stays at 1 until a `rdy_clr` pulse clears it at the next edge. If an accepted frame arrives in the same cycle as `rdy_clr`, `rx_ready` stays at 1.
- R9: `bit9_q` takes `rx_bit9` at the edge where a frame is accepted. It keeps its value across rejected frames and idle cycles.
- R10: At each `frame_done` edge, `addr_match` is loaded with 1 when the mode is 2 or 3, the ninth bit is 1, and R4 or R5 matches. This happens whatever `filt_en` is, and 0 is loaded otherwise. Between frames `addr_match` holds its value.
- R11: `en_wr` loads `en_wdata` into `filt_en` at the next edge. A frame in the same cycle as the write is judged with the old enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Serial mode: 0 shift, 1 8-bit async, 2 and 3 nine-bit |
| frame_done | input | 1 | One-cycle strobe marking a completed frame |
| rx_byte | input | 8 | Received byte |
| rx_bit9 | input | 1 | Received ninth bit |
| stop_ok | input | 1 | Stop bit of the frame was valid |
| slave_addr | input | 8 | Station address register |
| addr_mask | input | 8 | Address mask register (1 = compare) |
| en_wr | input | 1 | Write strobe for the filter enable |
| en_wdata | input | 1 | Value written to the filter enable |
| rdy_clr | input | 1 | Software clear of receive-ready |
| rx_ready | output | 1 | Receive-ready flag |
| bit9_q | output | 1 | Ninth bit of the last accepted frame |
| addr_match | output | 1 | Last frame was a matching address |
| filt_en | output | 1 | Current filter enable |

## Verification
The bench runs the same address byte through two mask settings. A byte that one mask accepts and the other rejects shows that mask bits act as don't-care positions. Broadcast patterns are tried with bytes that miss the station address, so only the broadcast path can accept them. Data frames are sent with the filter on and off, and with a write to the enable in the same cycle, which separates the filtering from the sampling time of the enable. Frames in modes 0 and 1 are sent with good and bad stop bits to show where the stop bit counts and where the enable is ignored.

// File: rtl/uaf_pkg.sv
package uaf_pkg;

    typedef enum logic [1:0] {
        SM_SHIFT  = 2'd0,
        SM_ASYNC8 = 2'd1,
        SM_NINE_A = 2'd2,
        SM_NINE_B = 2'd3
    } ser_mode_e;

    typedef struct packed {
        logic accept;
        logic addr_hit;
    } verdict_t;

    function automatic logic is_nine_bit(input ser_mode_e m);
        return (m == SM_NINE_A) || (m == SM_NINE_B);
    endfunction

endpackage

// File: rtl/uaf_addr_cmp.sv
module uaf_addr_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] cand,
    input  logic [W-1:0] station,
    input  logic [W-1:0] care,
    output logic         given_hit,
    output logic         bcast_hit
);
    logic [W-1:0] given_ok;
    logic [W-1:0] bcast_ok;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // masked station compare: care bit 0 -> don't care
        assign given_ok[i] = ~care[i] | (cand[i] == station[i]);
        // broadcast pattern: bits set in (station|care) must be set in cand
        assign bcast_ok[i] = ~(station[i] | care[i]) | cand[i];
    end

    assign given_hit = &given_ok;
    assign bcast_hit = &bcast_ok;
endmodule

// File: rtl/uaf_decide.sv
module uaf_decide
    import uaf_pkg::*;
(
    input  ser_mode_e mode,
    input  logic      bit9,
    input  logic      stop_ok,
    input  logic      en,
    input  logic      given_hit,
    input  logic      bcast_hit,
    output verdict_t  verdict
);
    logic addr_frame_hit;

    assign addr_frame_hit = is_nine_bit(mode) && bit9 && (given_hit || bcast_hit);

    always_comb begin
        verdict.addr_hit = addr_frame_hit;
        unique case (mode)
            SM_SHIFT:  verdict.accept = 1'b1;
            SM_ASYNC8: verdict.accept = !en || stop_ok;
            default:   verdict.accept = !en || addr_frame_hit;
        endcase
    end
endmodule

// File: rtl/uaf_enable_reg.sv
module uaf_enable_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic wdata,
    output logic en
);
    always_ff @(posedge clk) begin
        if (rst)     en <= 1'b0;
        else if (wr) en <= wdata;
    end
endmodule

// File: rtl/uart_addr_filter.sv
module uart_addr_filter
    import uaf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_bit9,
    input  logic              stop_ok,
    input  logic [DATA_W-1:0] slave_addr,
    input  logic [DATA_W-1:0] addr_mask,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              rdy_clr,
    output logic              rx_ready,
    output logic              bit9_q,
    output logic              addr_match,
    output logic              filt_en
);
    logic      given_hit;
    logic      bcast_hit;
    verdict_t  verdict;
    ser_mode_e mode_e;

    assign mode_e = ser_mode_e'(mode);

    uaf_enable_reg u_en (
        .clk   (clk),
        .rst   (rst),
        .wr    (en_wr),
        .wdata (en_wdata),
        .en    (filt_en)
    );

    uaf_addr_cmp #(.W(DATA_W)) u_cmp (
        .cand      (rx_byte),
        .station   (slave_addr),
        .care      (addr_mask),
        .given_hit (given_hit),
        .bcast_hit (bcast_hit)
    );

    uaf_decide u_dec (
        .mode      (mode_e),
        .bit9      (rx_bit9),
        .stop_ok   (stop_ok),
        .en        (filt_en),
        .given_hit (given_hit),
        .bcast_hit (bcast_hit),
        .verdict   (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_ready   <= 1'b0;
            bit9_q     <= 1'b0;
            addr_match <= 1'b0;
        end else begin
            if (frame_done) begin
                addr_match <= verdict.addr_hit;
                if (verdict.accept) begin
                    rx_ready <= 1'b1;
                    bit9_q   <= rx_bit9;
                end else if (rdy_clr) begin
                    rx_ready <= 1'b0;
                end
            end else if (rdy_clr) begin
                rx_ready <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uaf_checker.sv
module uaf_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       frame_done,
    input logic       rx_bit9,
    input logic       stop_ok,
    input logic       en_wr,
    input logic       en_wdata,
    input logic       rdy_clr,
    input logic       rx_ready,
    input logic       bit9_q,
    input logic       addr_match,
    input logic       filt_en
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!rx_ready && !bit9_q && !addr_match && !filt_en));

    a_r2_open_accept: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !filt_en) |=> rx_ready);

    a_r3_data_dropped: assert property (@(posedge clk) disable iff (rst)
        (frame_done && filt_en && mode[1] && !rx_bit9 && !rx_ready) |=> !rx_ready);

    a_r6_bad_stop: assert property (@(posedge clk) disable iff (rst)
        (frame_done && filt_en && mode == 2'd1 && !stop_ok && !rx_ready) |=> !rx_ready);

    a_r7_shift_mode: assert property (@(posedge clk) disable iff (rst)
        (frame_done && mode == 2'd0) |=> rx_ready);

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && !rdy_clr) |=> rx_ready);

    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (rdy_clr && !frame_done) |=> !rx_ready);

    a_r9_bit9_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> $stable(bit9_q));

    a_r10_match_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> $stable(addr_match));

    a_r10_no_match_data: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !rx_bit9) |=> !addr_match);

    a_r11_enable_write: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> (filt_en == $past(en_wdata)));
endmodule

bind uart_addr_filter uaf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .frame_done (frame_done),
    .rx_bit9    (rx_bit9),
    .stop_ok    (stop_ok),
    .en_wr      (en_wr),
    .en_wdata   (en_wdata),
    .rdy_clr    (rdy_clr),
    .rx_ready   (rx_ready),
    .bit9_q     (bit9_q),
    .addr_match (addr_match),
    .filt_en    (filt_en)
);

// File: tb/uart_addr_filter_test.sv
module uart_addr_filter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic       frame_done = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_bit9 = 1'b0;
    logic       stop_ok = 1'b0;
    logic [7:0] slave_addr = 8'h00;
    logic [7:0] addr_mask = 8'h00;
    logic       en_wr = 1'b0;
    logic       en_wdata = 1'b0;
    logic       rdy_clr = 1'b0;
    logic       rx_ready, bit9_q, addr_match, filt_en;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic  rdy;
        logic  b9;
        logic  hit;
        string tag;
    } exp_t;

    exp_t sb[$];

    logic m_rdy = 1'b0;
    logic m_b9  = 1'b0;
    logic m_en  = 1'b0;

    always #2 clk = ~clk;

    uart_addr_filter uut (
        .clk(clk), .rst(rst), .mode(mode), .frame_done(frame_done),
        .rx_byte(rx_byte), .rx_bit9(rx_bit9), .stop_ok(stop_ok),
        .slave_addr(slave_addr), .addr_mask(addr_mask),
        .en_wr(en_wr), .en_wdata(en_wdata), .rdy_clr(rdy_clr),
        .rx_ready(rx_ready), .bit9_q(bit9_q), .addr_match(addr_match),
        .filt_en(filt_en)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic hit_model(input logic [1:0] md, input logic [7:0] b, input logic n);
        logic [7:0] pat;
        logic       given, bc;
        pat   = slave_addr | addr_mask;
        given = ((b ^ slave_addr) & addr_mask) == 8'h00;   // R4
        bc    = (b & pat) == pat;                          // R5
        return (md >= 2'd2) && n && (given || bc);         // R10
    endfunction

    // drive one frame; expected result goes to the scoreboard
    task automatic frame(input logic [1:0] md, input logic [7:0] b, input logic n,
                         input logic st, input logic clr, input string tag);
        logic acc, h;
        h = hit_model(md, b, n);
        case (md)
            2'd0:    acc = 1'b1;                 // R7
            2'd1:    acc = !m_en || st;          // R6
            default: acc = !m_en || h;           // R2/R3/R4
        endcase
        if (acc) begin
            m_rdy = 1'b1;
            m_b9  = n;
        end else if (clr) begin
            m_rdy = 1'b0;
        end
        sb.push_back('{rdy: m_rdy, b9: m_b9, hit: h, tag: tag});
        mode = md; rx_byte = b; rx_bit9 = n; stop_ok = st; rdy_clr = clr;
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        rdy_clr = 1'b0;
        if (en_wr) m_en = en_wdata;
    endtask

    task automatic clear_ready();
        rdy_clr = 1'b1;
        @(negedge clk);
        rdy_clr = 1'b0;
        m_rdy = 1'b0;
        check(rx_ready == 1'b0, "R8 clear", rx_ready, 0);
    endtask

    task automatic write_en(input logic v);
        en_wr = 1'b1; en_wdata = v;
        @(negedge clk);
        en_wr = 1'b0;
        m_en = v;
        check(filt_en == v, "R11 enable write", filt_en, v);
    endtask

    // monitor: compare one edge after each frame strobe
    always begin
        @(posedge clk);
        if (frame_done && !rst) begin
            exp_t e;
            @(negedge clk);
            e = sb.pop_front();
            check(rx_ready == e.rdy, {e.tag, " rx_ready"}, rx_ready, e.rdy);
            check(bit9_q == e.b9, {e.tag, " bit9_q R9"}, bit9_q, e.b9);
            check(addr_match == e.hit, {e.tag, " addr_match R10"}, addr_match, e.hit);
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired R1 actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rx_ready == 0 && bit9_q == 0 && addr_match == 0 && filt_en == 0,
              "R1 reset", {rx_ready, bit9_q, addr_match, filt_en}, 0);
        rst = 1'b0;
        @(negedge clk);

        slave_addr = 8'hC0; addr_mask = 8'hFD;
        frame(2'd2, 8'h55, 1'b0, 1'b1, 1'b0, "R2 open data");
        clear_ready();
        frame(2'd1, 8'h11, 1'b0, 1'b0, 1'b0, "R2 open mode1 bad stop");
        clear_ready();

        write_en(1'b1);
        frame(2'd2, 8'h55, 1'b0, 1'b1, 1'b0, "R3 data dropped");
        frame(2'd3, 8'hC0, 1'b0, 1'b1, 1'b0, "R3 address value as data");
        frame(2'd2, 8'hC0, 1'b1, 1'b1, 1'b0, "R4 C0 mask FD");
        clear_ready();
        frame(2'd3, 8'hC2, 1'b1, 1'b1, 1'b0, "R4 C2 mask FD");
        clear_ready();
        frame(2'd2, 8'hC1, 1'b1, 1'b1, 1'b0, "R4 C1 rejected mask FD");
        // bit9_q stays 1 across rejected data frame (R9)
        frame(2'd2, 8'h00, 1'b0, 1'b1, 1'b0, "R9 hold on reject");
        clear_ready();

        addr_mask = 8'hFE;
        frame(2'd2, 8'hC1, 1'b1, 1'b1, 1'b0, "R4 C1 mask FE");
        clear_ready();
        frame(2'd2, 8'hC2, 1'b1, 1'b1, 1'b0, "R4 C2 rejected mask FE");
        frame(2'd2, 8'hFF, 1'b1, 1'b1, 1'b0, "R5 broadcast FF");
        clear_ready();
        addr_mask = 8'h0F; slave_addr = 8'h30;
        frame(2'd2, 8'h3F, 1'b1, 1'b1, 1'b0, "R5 broadcast 3F");
        clear_ready();
        frame(2'd2, 8'hBF, 1'b1, 1'b1, 1'b0, "R5 broadcast BF");
        clear_ready();
        frame(2'd2, 8'h2F, 1'b1, 1'b1, 1'b0, "R5 broadcast miss 2F");
        slave_addr = 8'h00; addr_mask = 8'h00;
        frame(2'd3, 8'h5A, 1'b1, 1'b1, 1'b0, "R5 zero pattern any");
        clear_ready();

        slave_addr = 8'hC0; addr_mask = 8'hFD;
        frame(2'd1, 8'h77, 1'b1, 1'b0, 1'b0, "R6 bad stop");
        frame(2'd1, 8'h77, 1'b0, 1'b1, 1'b0, "R6 good stop");
        clear_ready();
        frame(2'd0, 8'h12, 1'b1, 1'b0, 1'b0, "R7 shift mode ignores enable");

        // R8: ready sticky over idle cycles, set wins over clear
        repeat (4) @(negedge clk);
        check(rx_ready == 1'b1, "R8 sticky", rx_ready, 1);
        frame(2'd0, 8'h34, 1'b0, 1'b1, 1'b1, "R8 set beats clear");
        clear_ready();
        frame(2'd2, 8'h00, 1'b0, 1'b1, 1'b1, "R8 clear with rejected frame");

        // R10: match flagged while filter open, zero in mode 1
        write_en(1'b0);
        frame(2'd2, 8'hC2, 1'b1, 1'b1, 1'b0, "R10 hit while open");
        frame(2'd1, 8'hC2, 1'b1, 1'b1, 1'b0, "R10 mode1 no hit");
        clear_ready();

        // R11: frame in the write cycle sees old enable
        write_en(1'b1);
        en_wr = 1'b1; en_wdata = 1'b0;
        frame(2'd2, 8'h44, 1'b0, 1'b1, 1'b0, "R11 old enable used");
        en_wr = 1'b0;
        check(filt_en == 1'b0, "R11 enable after write", filt_en, 0);
        frame(2'd2, 8'h44, 1'b0, 1'b1, 1'b0, "R11 data after clear");

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule